// File: doc/BRIEF.md
# End-of-Chain Request Terminator

This block sits on a link port that has no device attached downstream, such as the far end of a chain driven by a single host. While the port is marked unconnected, the terminator takes every packet routed to that port. It discards response packets and posted requests without a reply.

A non-posted request is turned into an error response that reports a non-existent access. The response carries the request's source tag and unit ID. It goes back into the receive path, so that the opposite port's reflect buffers carry it on to the requester. Each sunk packet also sets a sticky bit in an error log. A mode input picks one of two bit layouts for that log. Software clears log bits by writing ones.

The response output uses a valid/ready handshake. While an error response waits to be taken, the block stops accepting input. As a result, at most one non-posted request is ever pending.

Top module: `eoc_terminator`

## Requirements
- R1: With `link_absent_i` low the block is idle. `pkt_ready_o` stays low, no response is produced, and the log does not change.
- R2: A packet of class 2'b00 (response) is accepted and dropped. It produces no output response.
- R3: A packet of class 2'b01 (posted request) is accepted and dropped. It produces no output response.
- R4: A packet of class 2'b10 (non-posted read) produces an error response. `rsp_valid_o` rises in the cycle after acceptance, with `rsp_kind_o`=0 (read response), `rsp_err_o`=1, and the request's tag and unit ID.
- R5: A packet of class 2'b11 (non-posted write) produces an error response with `rsp_kind_o`=1 (target done), `rsp_err_o`=1, and the request's tag and unit ID.
- R6: While a response is pending, `pkt_ready_o` is low. The response fields stay stable until a cycle in which `rsp_ready_i` is high.
- R7: With `log_mode_i`=1 (standard layout), log bit 0 flags a dropped response, bit 1 a dropped posted request, and bit 2 a terminated non-posted request. All other bits read 0.
- R8: With `log_mode_i`=0 (vendor layout), the same three flags appear at bits 4, 5 and 6. Bit 7 is the OR of the three flags, and all other bits read 0.
- R9: Log flags are sticky. A one in `log_clr_i` clears the flag at that bit position in the current layout; in vendor layout bit 7 clears all three flags. A new event in the same cycle as a clear wins, so the flag stays set.
- R10: After reset the log reads 0, no response is valid, and `pkt_ready_o` is high while `link_absent_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_absent_i | input | 1 | Port has no downstream connection; enables the block |
| pkt_valid_i | input | 1 | Incoming packet valid |
| pkt_ready_o | output | 1 | Incoming packet accepted this cycle when valid |
| pkt_class_i | input | 2 | 00 response, 01 posted, 10 non-posted read, 11 non-posted write |
| pkt_tag_i | input | TAG_W | Source tag of the packet |
| pkt_unit_i | input | UNIT_W | Unit ID of the packet |
| rsp_valid_o | output | 1 | Error response valid |
| rsp_ready_i | input | 1 | Receive path takes the response |
| rsp_kind_o | output | 1 | 0 read response, 1 target done |
| rsp_tag_o | output | TAG_W | Copied source tag |
| rsp_unit_o | output | UNIT_W | Copied unit ID |
| rsp_err_o | output | 1 | Non-existent-access error flag |
| log_mode_i | input | 1 | 1 standard layout, 0 vendor layout |
| log_clr_i | input | LOG_W | Write-one-to-clear strobe in current layout |
| log_o | output | LOG_W | Error log view |

## Verification
The bench stalls the response output and then checks three things. The input must refuse new packets, and the held tag must not move. A design that took a second request would overwrite the pending one or lose it. A scoreboard matches every reflected response against the requests sent, so a design that swapped read and write kinds, or dropped a non-posted request silently, shows up as a mismatch or a leftover entry.

The log is read in both layouts after a clear at one layout's position. This catches a clear decoded at the wrong bit positions. It also drives a clear and a new event in the same cycle; a design that gave the clear priority would lose that event. Finally, traffic is offered while the link is present, and any acceptance or log change then counts as a failure.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  typedef enum logic [1:0] {
    CLS_RSP    = 2'b00,
    CLS_POSTED = 2'b01,
    CLS_NP_RD  = 2'b10,
    CLS_NP_WR  = 2'b11
  } pkt_cls_e;

  typedef enum logic {
    RK_READ = 1'b0,
    RK_DONE = 1'b1
  } rsp_kind_e;

  localparam int FLAG_N = 3;

  // bit order is the standard-layout order
  typedef struct packed {
    logic np;
    logic posted;
    logic rsp;
  } drop_flags_t;
endpackage

// File: rtl/eoc_classify.sv
module eoc_classify
  import eoc_pkg::*;
(
  input  logic        accept_i,
  input  pkt_cls_e    cls_i,
  output drop_flags_t hit_o,
  output logic        np_load_o,
  output rsp_kind_e   kind_o
);
  always_comb begin
    hit_o     = '0;
    np_load_o = 1'b0;
    kind_o    = RK_READ;
    if (accept_i) begin
      unique case (cls_i)
        CLS_RSP:    hit_o.rsp    = 1'b1;
        CLS_POSTED: hit_o.posted = 1'b1;
        CLS_NP_RD: begin
          hit_o.np  = 1'b1;
          np_load_o = 1'b1;
          kind_o    = RK_READ;
        end
        CLS_NP_WR: begin
          hit_o.np  = 1'b1;
          np_load_o = 1'b1;
          kind_o    = RK_DONE;
        end
        default: hit_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/eoc_rsp_slot.sv
module eoc_rsp_slot
  import eoc_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int UNIT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  rsp_kind_e         kind_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic              ready_i,
  output logic              valid_o,
  output rsp_kind_e         kind_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= RK_READ;
      tag_o   <= '0;
      unit_o  <= '0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      kind_o  <= kind_i;
      tag_o   <= tag_i;
      unit_o  <= unit_i;
      err_o   <= 1'b1;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/eoc_err_log.sv
module eoc_err_log
  import eoc_pkg::*;
#(
  parameter int LOG_W   = 8,
  parameter int VND_LSB = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  drop_flags_t      set_i,
  input  logic             mode_std_i,
  input  logic [LOG_W-1:0] clr_i,
  output logic [LOG_W-1:0] log_o
);
  localparam int VND_SUM = VND_LSB + FLAG_N;

  logic [FLAG_N-1:0] flag_q;
  logic [FLAG_N-1:0] set_vec;

  assign set_vec = set_i;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic clr_hit;
    assign clr_hit = mode_std_i ? clr_i[i] : (clr_i[VND_LSB+i] | clr_i[VND_SUM]);
    // new event outranks a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_hit)    flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    log_o = '0;
    if (mode_std_i) begin
      log_o[FLAG_N-1:0] = flag_q;
    end else begin
      log_o[VND_LSB +: FLAG_N] = flag_q;
      log_o[VND_SUM]           = |flag_q;
    end
  end
endmodule

// File: rtl/eoc_terminator.sv
module eoc_terminator
  import eoc_pkg::*;
#(
  parameter int TAG_W   = 5,
  parameter int UNIT_W  = 5,
  parameter int LOG_W   = 8,
  parameter int VND_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_absent_i,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [1:0]        pkt_class_i,
  input  logic [TAG_W-1:0]  pkt_tag_i,
  input  logic [UNIT_W-1:0] pkt_unit_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_kind_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [UNIT_W-1:0] rsp_unit_o,
  output logic              rsp_err_o,
  input  logic              log_mode_i,
  input  logic [LOG_W-1:0]  log_clr_i,
  output logic [LOG_W-1:0]  log_o
);
  drop_flags_t hit;
  logic        np_load;
  logic        accept;
  rsp_kind_e   kind_in;
  rsp_kind_e   kind_q;

  // single pending slot: stall input while a response waits
  assign pkt_ready_o = link_absent_i & ~rsp_valid_o;
  assign accept      = pkt_valid_i & pkt_ready_o;

  eoc_classify u_cls (
    .accept_i (accept),
    .cls_i    (pkt_cls_e'(pkt_class_i)),
    .hit_o    (hit),
    .np_load_o(np_load),
    .kind_o   (kind_in)
  );

  eoc_rsp_slot #(.TAG_W(TAG_W), .UNIT_W(UNIT_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (np_load),
    .kind_i (kind_in),
    .tag_i  (pkt_tag_i),
    .unit_i (pkt_unit_i),
    .ready_i(rsp_ready_i),
    .valid_o(rsp_valid_o),
    .kind_o (kind_q),
    .tag_o  (rsp_tag_o),
    .unit_o (rsp_unit_o),
    .err_o  (rsp_err_o)
  );

  assign rsp_kind_o = kind_q;

  eoc_err_log #(.LOG_W(LOG_W), .VND_LSB(VND_LSB)) u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (hit),
    .mode_std_i(log_mode_i),
    .clr_i     (log_clr_i),
    .log_o     (log_o)
  );
endmodule

// File: rtl/eoc_terminator_chk.sv
module eoc_terminator_chk #(
  parameter int TAG_W   = 5,
  parameter int UNIT_W  = 5,
  parameter int LOG_W   = 8,
  parameter int VND_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              link_absent_i,
  input logic              pkt_valid_i,
  input logic              pkt_ready_o,
  input logic [1:0]        pkt_class_i,
  input logic [TAG_W-1:0]  pkt_tag_i,
  input logic [UNIT_W-1:0] pkt_unit_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic              rsp_kind_o,
  input logic [TAG_W-1:0]  rsp_tag_o,
  input logic [UNIT_W-1:0] rsp_unit_o,
  input logic              rsp_err_o,
  input logic              log_mode_i,
  input logic [LOG_W-1:0]  log_clr_i,
  input logic [LOG_W-1:0]  log_o
);
  p_idle_when_linked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_absent_i |-> !pkt_ready_o);

  p_drop_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && !pkt_class_i[1]) |=> !rsp_valid_o);

  p_np_reflect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && pkt_class_i[1]) |=>
      (rsp_valid_o && rsp_err_o && rsp_tag_o == $past(pkt_tag_i)
       && rsp_unit_o == $past(pkt_unit_i)));

  p_kind_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o && pkt_class_i[1]) |=> rsp_kind_o == $past(pkt_class_i[0]));

  p_one_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !pkt_ready_o);

  p_rsp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_unit_o) && $stable(rsp_kind_o)));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_clr_i == '0) |=> (!$stable(log_mode_i) || ((log_o & $past(log_o)) == $past(log_o))));
endmodule

bind eoc_terminator eoc_terminator_chk #(
  .TAG_W(TAG_W), .UNIT_W(UNIT_W), .LOG_W(LOG_W), .VND_LSB(VND_LSB)
) u_chk (.*);

// File: tb/eoc_terminator_tb_top.sv
`timescale 1ns/1ps
module eoc_terminator_tb_top;
  localparam int TAG_W  = 5;
  localparam int UNIT_W = 5;
  localparam int LOG_W  = 8;
  localparam int EXP_W  = 1 + TAG_W + UNIT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_absent = 1'b1;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [1:0] pkt_class = '0;
  logic [TAG_W-1:0] pkt_tag = '0;
  logic [UNIT_W-1:0] pkt_unit = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_kind;
  logic [TAG_W-1:0] rsp_tag;
  logic [UNIT_W-1:0] rsp_unit;
  logic rsp_err;
  logic log_mode = 1'b1;
  logic [LOG_W-1:0] log_clr = '0;
  logic [LOG_W-1:0] log_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [EXP_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  eoc_terminator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .link_absent_i(link_absent),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_class_i(pkt_class),
    .pkt_tag_i(pkt_tag), .pkt_unit_i(pkt_unit),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_kind_o(rsp_kind),
    .rsp_tag_o(rsp_tag), .rsp_unit_o(rsp_unit), .rsp_err_o(rsp_err),
    .log_mode_i(log_mode), .log_clr_i(log_clr), .log_o(log_val)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: waits for ready, pushes expected response for non-posted classes
  task automatic send(input logic [1:0] cls, input logic [TAG_W-1:0] t, input logic [UNIT_W-1:0] u);
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_class = cls; pkt_tag = t; pkt_unit = u; pkt_valid = 1'b1;
    if (cls[1]) exp_q.push_back({cls[0], t, u});
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // monitor: compares each handshaken response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3 unexpected response", {rsp_kind, rsp_tag, rsp_unit}, 0);
      end else begin
        logic [EXP_W-1:0] e;
        e = exp_q.pop_front();
        chk({rsp_kind, rsp_tag, rsp_unit} == e, "R4/R5 response fields",
            {rsp_kind, rsp_tag, rsp_unit}, e);
        chk(rsp_err == 1'b1, "R4 error flag", rsp_err, 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(log_val == 0, "R10 log after reset", log_val, 0);
    chk(!rsp_valid, "R10 no response after reset", rsp_valid, 0);
    chk(pkt_ready, "R10 ready after reset", pkt_ready, 1);

    send(2'b00, 5'h01, 5'h02);
    chk(log_val == 8'h01, "R2 R7 response dropped, logged", log_val, 8'h01);
    chk(!rsp_valid, "R2 no output", rsp_valid, 0);
    send(2'b01, 5'h03, 5'h04);
    chk(log_val == 8'h03, "R3 R7 posted dropped, logged", log_val, 8'h03);
    chk(!rsp_valid, "R3 no output", rsp_valid, 0);

    send(2'b10, 5'h05, 5'h03);
    chk(rsp_valid, "R4 response valid next cycle", rsp_valid, 1);
    chk(log_val == 8'h07, "R7 non-posted logged", log_val, 8'h07);
    send(2'b11, 5'h1f, 5'h11);
    repeat (2) @(negedge clk);

    log_mode = 1'b0;
    @(negedge clk);
    chk(log_val == 8'hF0, "R8 vendor layout", log_val, 8'hF0);
    log_clr = 8'h20;
    @(negedge clk);
    log_clr = '0;
    chk(log_val == 8'hD0, "R9 vendor clear posted", log_val, 8'hD0);
    log_mode = 1'b1;
    @(negedge clk);
    chk(log_val == 8'h05, "R9 R7 same flags in standard view", log_val, 8'h05);
    repeat (3) @(negedge clk);
    chk(log_val == 8'h05, "R9 sticky", log_val, 8'h05);
    log_mode = 1'b0;
    log_clr = 8'h80;
    @(negedge clk);
    log_clr = '0;
    chk(log_val == 8'h00, "R9 vendor summary clears all", log_val, 0);

    // clear and new event in the same cycle
    log_mode = 1'b1;
    pkt_class = 2'b00; pkt_valid = 1'b1; log_clr = 8'h01;
    @(negedge clk);
    pkt_valid = 1'b0; log_clr = '0;
    chk(log_val == 8'h01, "R9 set wins over clear", log_val, 8'h01);

    // stall the response output
    rsp_ready = 1'b0;
    send(2'b10, 5'h09, 5'h0A);
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid && !pkt_ready, "R6 stalled, input held off", {rsp_valid, pkt_ready}, 2'b10);
      chk(rsp_tag == 5'h09 && rsp_unit == 5'h0A, "R6 fields stable", {rsp_tag, rsp_unit}, {5'h09, 5'h0A});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(pkt_ready && !rsp_valid, "R6 released", {rsp_valid, pkt_ready}, 2'b01);

    // link present: block must stay idle
    log_clr = 8'h07;
    @(negedge clk);
    log_clr = '0;
    link_absent = 1'b0;
    pkt_class = 2'b10; pkt_tag = 5'h02; pkt_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!pkt_ready && !rsp_valid, "R1 idle when linked", {pkt_ready, rsp_valid}, 0);
      chk(log_val == 0, "R1 log untouched", log_val, 0);
    end
    pkt_valid = 1'b0;
    link_absent = 1'b1;

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R5 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule